// File: doc/BRIEF.md
# System-to-DRAM Address Normalizer

This block turns a 40-bit system physical address into the local address that one memory node's DRAM controller uses when it compares against its chip-select ranges. Each request carries the address together with the node's configuration: a lower and upper address bound, a node-interleave mask and select value, and the size of the memory hole that was hoisted above 4 GiB. The block decides whether this node owns the address. If it does, it removes the hoisted hole, rebases the address to the node's start and squeezes out the address bits that pick between interleaved nodes.

The block returns one registered verdict per request: hit, miss or configuration error. On a hit it also returns the 36-bit normalized address. Downstream logic takes the hit address straight into chip-select matching. A miss tells the caller to try the next node. A configuration error marks an interleave mask the node can never legally hold.

Top module: `sdn_addr_normalizer`

## Requirements
- R1: When cfg_base equals cfg_limit the node maps nothing, and every request returns miss, whatever the address and the other fields hold.
- R2: A request can hit only when cfg_base <= req_addr <= cfg_limit, with both bounds inclusive. An address outside this range returns miss. This check uses the unadjusted address and takes priority over R5.
- R3: When cfg_hole is nonzero and req_addr is 0x1_0000_0000 or above, cfg_hole is subtracted from the address, modulo 2^40, before every later step, including the interleave check of R6. Otherwise the address passes unchanged.
- R4: The rebased address is the adjusted address minus cfg_base with cfg_base bits [23:0] forced to zero, modulo 2^40.
- R5: cfg_ilv_en must be 0, 1, 3 or 7. For an in-range request (R1, R2), any other value returns cfg_err.
- R6: With cfg_ilv_en nonzero, the node is selected only when (adjusted address bits [14:12] AND cfg_ilv_en) equals the full 3-bit cfg_ilv_sel. Otherwise the request returns miss. With cfg_ilv_en zero, cfg_ilv_sel is ignored.
- R7: On a hit, out_addr[11:0] equals rebased bits [11:0]. out_addr[35:12] equals rebased bits [35+k:12+k], where k is 0, 1, 2 or 3 for cfg_ilv_en of 0, 1, 3 or 7.
- R8: A request sampled with req_valid high at a rising edge produces out_valid high for exactly the following cycle. With req_valid low, out_valid is low one cycle later.
- R9: When out_valid is high, exactly one of out_hit, out_miss and out_cfg_err is high. When out_valid is low, all three are low. out_addr is zero unless out_hit is high.
- R10: A synchronous active-low reset clears out_valid, all three flags and out_addr, and requests sampled while reset is low are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe; inputs are sampled when high |
| req_addr | input | 40 | System physical address |
| cfg_base | input | 40 | Lowest address owned by the node |
| cfg_limit | input | 40 | Highest address owned by the node |
| cfg_ilv_en | input | 3 | Node-interleave mask (0, 1, 3 or 7) |
| cfg_ilv_sel | input | 3 | This node's interleave position |
| cfg_hole | input | 40 | Size of the hoisted memory hole, 0 if none |
| out_valid | output | 1 | Result strobe, one cycle after req_valid |
| out_hit | output | 1 | Address belongs to this node |
| out_miss | output | 1 | Address not owned by this node |
| out_cfg_err | output | 1 | Illegal interleave mask |
| out_addr | output | 36 | Normalized DRAM address, zero unless hit |

## Verification
The bench targets the exact range bounds and the addresses one past each bound. A design with an off-by-one comparison would flip hit and miss there. It also drives addresses just below and at 4 GiB with a nonzero hole. A design that tests the threshold on the wrong address, or takes interleave bits before the hole is removed, would return a wrong normalized address or a wrong select. The bench sends each legal mask and the illegal masks, plus select values with bits outside the mask, so a wrong shift amount, a masked select compare or a missing error verdict shows up in out_addr or in the flags. It also checks a zero-size node whose limit equals base, which must miss even though the address equals both bounds.

// File: rtl/sdn_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the address normalizer.
package sdn_pkg;

    // Outcome of one normalization request.
    typedef enum logic [1:0] {
        SDN_MISS    = 2'd0,
        SDN_HIT     = 2'd1,
        SDN_CFG_ERR = 2'd2
    } sdn_verdict_e;

    // A legal interleave mask is a run of ones from bit 0 (0, 1, 3, 7, ...).
    function automatic logic mask_is_legal(input logic [15:0] m);
        return ((m & (m + 16'd1)) == 16'd0);
    endfunction

endpackage

// File: rtl/sdn_range_gate.sv
`timescale 1ns/1ps
// Decides whether an address lies inside the node's inclusive window.
// Assumes: a window whose base equals its limit is an empty node.
module sdn_range_gate #(
    parameter int PA_W = 40
) (
    input  logic [PA_W-1:0] addr,
    input  logic [PA_W-1:0] base,
    input  logic [PA_W-1:0] limit,
    output logic            in_range
);
    logic empty_node;

    // Window test with both bounds inclusive; an empty node owns nothing.
    always_comb begin
        empty_node = (base == limit);
        in_range   = !empty_node && (addr >= base) && (addr <= limit);
    end
endmodule

// File: rtl/sdn_rebase.sv
`timescale 1ns/1ps
// Removes the hoisted memory hole and subtracts the node base.
// Assumes: the base counts only at BASE_GRAN granularity; lower bits are dropped.
module sdn_rebase #(
    parameter int PA_W      = 40,
    parameter int BASE_GRAN = 24,
    parameter int HOLE_BIT  = 32
) (
    input  logic [PA_W-1:0] addr,
    input  logic [PA_W-1:0] base,
    input  logic [PA_W-1:0] hole,
    output logic [PA_W-1:0] adj_addr,
    output logic [PA_W-1:0] rebased
);
    localparam int HI_W = PA_W - HOLE_BIT;

    logic            above_hole;
    logic [PA_W-1:0] base_floor;

    // Hole removal for addresses at or above 2^HOLE_BIT, then base subtraction.
    always_comb begin
        above_hole = (addr[PA_W-1:HOLE_BIT] != {HI_W{1'b0}});
        adj_addr   = ((hole != '0) && above_hole) ? (addr - hole) : addr;
        base_floor = {base[PA_W-1:BASE_GRAN], {BASE_GRAN{1'b0}}};
        rebased    = adj_addr - base_floor;
    end
endmodule

// File: rtl/sdn_ilv_excise.sv
`timescale 1ns/1ps
// Checks the interleave mask, tests node selection and removes interleave bits.
// Assumes: the mask is a run of ones of length k; bits [PAGE_LSB +: k] are cut out.
module sdn_ilv_excise #(
    parameter int PA_W     = 40,
    parameter int OUT_W    = 36,
    parameter int PAGE_LSB = 12,
    parameter int ILV_W    = 3
) (
    input  logic [PA_W-1:0]  rebased,
    input  logic [ILV_W-1:0] sel_bits,
    input  logic [ILV_W-1:0] ilv_en,
    input  logic [ILV_W-1:0] ilv_sel,
    output logic             legal,
    output logic             selected,
    output logic [OUT_W-1:0] norm_addr
);
    import sdn_pkg::*;

    localparam int NCAND = ILV_W + 1;
    localparam int LOG_W = $clog2(NCAND);
    localparam int TOP_W = OUT_W - PAGE_LSB;

    logic [OUT_W-1:0] cand [NCAND];
    logic [LOG_W-1:0] ilv_log;

    // One candidate layout per interleave width k.
    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        assign cand[k] = {rebased[OUT_W-1+k -: TOP_W], rebased[PAGE_LSB-1:0]};
    end

    // Legality, width of the mask and selection compare.
    always_comb begin
        legal   = mask_is_legal({{(16-ILV_W){1'b0}}, ilv_en});
        ilv_log = '0;
        for (int i = 0; i < ILV_W; i++) begin
            ilv_log = ilv_log + LOG_W'(ilv_en[i]);
        end
        selected  = ((sel_bits & ilv_en) == ilv_sel);
        norm_addr = cand[ilv_log];
    end
endmodule

// File: rtl/sdn_addr_normalizer.sv
`timescale 1ns/1ps
// Top: normalizes a system address for one memory node and registers the verdict.
// Assumes: configuration is stable while req_valid is high; one result per request.
module sdn_addr_normalizer #(
    parameter int PA_W      = 40,
    parameter int OUT_W     = 36,
    parameter int BASE_GRAN = 24,
    parameter int HOLE_BIT  = 32,
    parameter int PAGE_LSB  = 12,
    parameter int ILV_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [PA_W-1:0]  req_addr,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [PA_W-1:0]  cfg_limit,
    input  logic [ILV_W-1:0] cfg_ilv_en,
    input  logic [ILV_W-1:0] cfg_ilv_sel,
    input  logic [PA_W-1:0]  cfg_hole,
    output logic             out_valid,
    output logic             out_hit,
    output logic             out_miss,
    output logic             out_cfg_err,
    output logic [OUT_W-1:0] out_addr
);
    import sdn_pkg::*;

    logic             in_range;
    logic [PA_W-1:0]  adj_addr;
    logic [PA_W-1:0]  rebased;
    logic             legal;
    logic             selected;
    logic [OUT_W-1:0] norm_addr;
    sdn_verdict_e     verdict;

    sdn_range_gate #(.PA_W(PA_W)) u_range (
        .addr(req_addr), .base(cfg_base), .limit(cfg_limit), .in_range(in_range)
    );

    sdn_rebase #(.PA_W(PA_W), .BASE_GRAN(BASE_GRAN), .HOLE_BIT(HOLE_BIT)) u_rebase (
        .addr(req_addr), .base(cfg_base), .hole(cfg_hole),
        .adj_addr(adj_addr), .rebased(rebased)
    );

    sdn_ilv_excise #(.PA_W(PA_W), .OUT_W(OUT_W), .PAGE_LSB(PAGE_LSB), .ILV_W(ILV_W)) u_ilv (
        .rebased(rebased), .sel_bits(adj_addr[PAGE_LSB +: ILV_W]),
        .ilv_en(cfg_ilv_en), .ilv_sel(cfg_ilv_sel),
        .legal(legal), .selected(selected), .norm_addr(norm_addr)
    );

    // Verdict priority: window, then mask legality, then interleave selection.
    always_comb begin
        if (!in_range)                               verdict = SDN_MISS;
        else if (!legal)                             verdict = SDN_CFG_ERR;
        else if ((cfg_ilv_en != '0) && !selected)    verdict = SDN_MISS;
        else                                         verdict = SDN_HIT;
    end

    // Result register: one-cycle strobe with flags and the hit address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_hit     <= 1'b0;
            out_miss    <= 1'b0;
            out_cfg_err <= 1'b0;
            out_addr    <= '0;
        end else begin
            out_valid   <= req_valid;
            out_hit     <= req_valid && (verdict == SDN_HIT);
            out_miss    <= req_valid && (verdict == SDN_MISS);
            out_cfg_err <= req_valid && (verdict == SDN_CFG_ERR);
            out_addr    <= (req_valid && (verdict == SDN_HIT)) ? norm_addr : '0;
        end
    end

    // R8
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R8
    valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R9
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({out_hit, out_miss, out_cfg_err}) == 1));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_hit || out_miss || out_cfg_err));

    // R9
    miss_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_hit |-> (out_addr == '0));

    // R1
    empty_node_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (cfg_base == cfg_limit)) |=> out_miss);

    // R2
    hit_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ((req_addr < cfg_base) || (req_addr > cfg_limit))) |=> out_miss);

    // R5
    cfg_err_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(cfg_ilv_en == 3'd0 || cfg_ilv_en == 3'd1 ||
                        cfg_ilv_en == 3'd3 || cfg_ilv_en == 3'd7)
                   && (cfg_base != cfg_limit)
                   && (req_addr >= cfg_base) && (req_addr <= cfg_limit)) |=> out_cfg_err);
endmodule

// File: tb/sim_sdn_addr_normalizer.sv
`timescale 1ns/1ps
module sim_sdn_addr_normalizer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic [39:0] cfg_base = '0;
    logic [39:0] cfg_limit = '0;
    logic [2:0]  cfg_ilv_en = '0;
    logic [2:0]  cfg_ilv_sel = '0;
    logic [39:0] cfg_hole = '0;
    logic        out_valid, out_hit, out_miss, out_cfg_err;
    logic [35:0] out_addr;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    sdn_addr_normalizer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_ilv_en(cfg_ilv_en),
        .cfg_ilv_sel(cfg_ilv_sel), .cfg_hole(cfg_hole), .out_valid(out_valid),
        .out_hit(out_hit), .out_miss(out_miss), .out_cfg_err(out_cfg_err),
        .out_addr(out_addr)
    );

    // Expected {valid, hit, miss, err, addr} from the requirements.
    function automatic logic [39:0] model(input logic [39:0] a, input logic [39:0] b,
                                          input logic [39:0] l, input logic [2:0] en,
                                          input logic [2:0] sel, input logic [39:0] h);
        logic [39:0] pa, dram, bfl;
        logic [35:0] na;
        int k;
        if (b == l) return {4'b1010, 36'd0};                        // R1
        if (a < b || a > l) return {4'b1010, 36'd0};                // R2
        if (!(en == 0 || en == 1 || en == 3 || en == 7))
            return {4'b1001, 36'd0};                                // R5
        pa = (h != 0 && a >= 40'h01_0000_0000) ? a - h : a;         // R3
        if (en != 0 && ((pa[14:12] & en) != sel))
            return {4'b1010, 36'd0};                                // R6
        bfl  = {b[39:24], 24'd0};
        dram = pa - bfl;                                            // R4
        k    = (en == 1) ? 1 : (en == 3) ? 2 : (en == 7) ? 3 : 0;
        na   = {24'(dram >> (12 + k)), dram[11:0]};                 // R7
        return {4'b1100, na};
    endfunction

    task automatic check(input logic [39:0] got, input logic [39:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got v/h/m/e=%b addr=%h expected v/h/m/e=%b addr=%h",
                     tag, got[39:36], got[35:0], exp[39:36], exp[35:0]);
        end
    endtask

    function automatic logic [39:0] outs();
        return {out_valid, out_hit, out_miss, out_cfg_err, out_addr};
    endfunction

    // Drive one request at a falling edge and check it at the next one.
    task automatic run(input logic [39:0] a, input logic [39:0] b, input logic [39:0] l,
                       input logic [2:0] en, input logic [2:0] sel, input logic [39:0] h,
                       input string tag);
        req_valid = 1'b1; req_addr = a; cfg_base = b; cfg_limit = l;
        cfg_ilv_en = en; cfg_ilv_sel = sel; cfg_hole = h;
        @(negedge clk);
        check(outs(), model(a, b, l, en, sel, h), tag);
    endtask

    initial begin
        #(200000 * 10);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(outs(), 40'd0, "R10 reset clears outputs");
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        check(outs(), 40'd0, "R8 idle gives no strobe");

        // Directed corners.
        run(40'h00_4000_0000, 40'h00_4000_0000, 40'h00_4000_0000, 3'd0, 3'd0, 40'd0, "R1 empty node");
        run(40'h00_0000_0000, 40'h00_0000_0000, 40'h00_0000_0000, 3'd1, 3'd0, 40'd0, "R1 zero node");
        run(40'h00_4000_0000, 40'h00_4000_0000, 40'h00_7FFF_FFFF, 3'd0, 3'd0, 40'd0, "R2 at base");
        run(40'h00_7FFF_FFFF, 40'h00_4000_0000, 40'h00_7FFF_FFFF, 3'd0, 3'd0, 40'd0, "R2 at limit");
        run(40'h00_8000_0000, 40'h00_4000_0000, 40'h00_7FFF_FFFF, 3'd0, 3'd0, 40'd0, "R2 past limit");
        run(40'h00_3FFF_FFFF, 40'h00_4000_0000, 40'h00_7FFF_FFFF, 3'd0, 3'd0, 40'd0, "R2 below base");
        run(40'h00_FFFF_FFFF, 40'h00_0000_0000, 40'h03_FFFF_FFFF, 3'd0, 3'd0, 40'h00_4000_0000, "R3 below 4G");
        run(40'h01_0000_0000, 40'h00_0000_0000, 40'h03_FFFF_FFFF, 3'd0, 3'd0, 40'h00_4000_0000, "R3 at 4G");
        run(40'h01_2345_6789, 40'h00_0000_0000, 40'h03_FFFF_FFFF, 3'd1, 3'd1, 40'h00_0000_1000, "R3 R6 sel after hole");
        run(40'h02_1234_5678, 40'h01_00AB_CDEF, 40'h03_FFFF_FFFF, 3'd0, 3'd0, 40'd0, "R4 base low bits dropped");
        run(40'h00_1000_0000, 40'h00_0000_0000, 40'h00_FFFF_FFFF, 3'd2, 3'd0, 40'd0, "R5 mask 2");
        run(40'h00_1000_0000, 40'h00_0000_0000, 40'h00_FFFF_FFFF, 3'd5, 3'd5, 40'd0, "R5 mask 5");
        run(40'h01_1000_0000, 40'h00_0000_0000, 40'h00_FFFF_FFFF, 3'd6, 3'd0, 40'd0, "R2 beats R5");
        run(40'h00_1234_5000, 40'h00_0000_0000, 40'h00_FFFF_FFFF, 3'd3, 3'd1, 40'd0, "R6 select match");
        run(40'h00_1234_5000, 40'h00_0000_0000, 40'h00_FFFF_FFFF, 3'd3, 3'd2, 40'd0, "R6 select mismatch");
        run(40'h00_1234_5000, 40'h00_0000_0000, 40'h00_FFFF_FFFF, 3'd1, 3'd3, 40'd0, "R6 sel outside mask");
        run(40'h00_1234_5000, 40'h00_0000_0000, 40'h00_FFFF_FFFF, 3'd0, 3'd6, 40'd0, "R6 sel ignored");
        for (int e = 0; e < 4; e++) begin
            logic [2:0] m;
            m = 3'((1 << e) - 1);
            run(40'h7F_FFFF_F000 | 40'(e << 12), 40'h00_0000_0000, 40'hFF_FFFF_FFFF,
                m, m & 3'(e), 40'd0, "R7 shift layout");
        end

        // Random mix.
        for (int i = 0; i < 400; i++) begin
            logic [39:0] b, l, a, h, span;
            logic [2:0] en, sel;
            b = {$urandom, $urandom};
            span = 40'({$urandom, $urandom} >> ($urandom % 40));
            l = b + span;
            if (l < b) l = 40'hFF_FFFF_FFFF;
            if ($urandom % 16 == 0) l = b;
            if ($urandom % 4 != 0) a = b + 40'({$urandom, $urandom} % (64'(l - b) + 64'd1));
            else a = {$urandom, $urandom};
            case ($urandom % 5)
                0: en = 3'd0;
                1: en = 3'd1;
                2: en = 3'd3;
                3: en = 3'd7;
                default: en = 3'($urandom);
            endcase
            sel = ($urandom % 4 == 0) ? 3'($urandom) : (3'($urandom) & en);
            h = ($urandom % 3 == 0) ? 40'd0 : {8'd0, $urandom} & 40'hFF_FF00_0000;
            run(a, b, l, en, sel, h, "R1..R9 random");
        end

        req_valid = 1'b0;
        @(negedge clk);
        check(outs(), 40'd0, "R8 R9 strobe ends");

        req_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check(outs(), 40'd0, "R10 request dropped in reset");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule